// File: doc/BRIEF.md
# Shared Instruction-Memory Port Arbiter

This block lets an instruction-fetch port and a data load/store port share a single-port tightly-coupled memory. Every cycle it grants at most one memory access. A store holds the memory for two consecutive cycles: the grant cycle and a tail cycle in which the array is written. While the tail cycle runs, neither port can be served.

Each port has a stall output. A stall is raised in any cycle where the port requests and is not granted. A stalled requester keeps its request, address and write data steady until the stall drops. Read data for a granted fetch or load appears on the read-data outputs in the cycle after the grant.

The priority order is fixed:
- A store that finds the memory free wins the cycle.
- Otherwise a fetch wins.
- A load is served only when nothing else competes.

This order gives fixed stall counts. A load that collides with a fetch loses exactly one cycle. A fetch that collides with a store loses two cycles.

Top module: `tcm_port_arbiter`

## Requirements
- R1: After the synchronous active-low reset is released, no store tail is pending. A fetch in the first cycle is granted with no stall, and with no request neither stall output is high.
- R2: A fetch while the data port is idle or loading completes with zero stall cycles, and single or back-to-back fetches all see zero stalls. Its data (`if_rdata`) equals the memory word at `if_addr` one cycle after the grant.
- R3: A load with no fetch in the same cycle and no store tail pending completes with zero stall cycles. Its data (`d_rdata`) equals the word at `d_addr` one cycle after the grant.
- R4: When a fetch and a load request in the same free cycle, the fetch is granted and the load stalls for exactly one cycle.
- R5: A granted store makes the following cycle unavailable: any fetch or data request in that tail cycle is stalled.
- R6: A store and a fetch requested together in a free cycle: the store is granted without stall and the fetch stalls for exactly two cycles.
- R7: A store directly followed by a load or by another store stalls the second access for exactly one cycle. Two back-to-back stores followed by a fetch in the second store's grant cycle stall that fetch for two cycles.
- R8: The write data of a store is stored at its address and is returned by any later load or fetch of that address.
- R9: A stall output is high only in cycles where its port's request is high.
- R10: A reset asserted during a store's tail cycle cancels that store's array write, and the old word stays at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| if_req | input | 1 | Fetch request |
| if_addr | input | ADDR_W | Fetch word address |
| if_stall | output | 1 | Fetch not granted this cycle |
| if_rdata | output | DATA_W | Fetch read data, valid the cycle after the grant |
| d_req | input | 1 | Data request |
| d_we | input | 1 | 1 = store, 0 = load |
| d_addr | input | ADDR_W | Data word address |
| d_wdata | input | DATA_W | Store data |
| d_stall | output | 1 | Data access not granted this cycle |
| d_rdata | output | DATA_W | Load read data, valid the cycle after the grant |

## Verification
Directed sequences exercise each collision on its own:
- A fetch alone, and a load alone, show the zero-stall paths.
- A fetch plus a load separates the one-cycle loss of a lost load from the two-cycle loss of a fetch behind a store.
- A store followed by a load, and a store followed by a store, isolate the tail cycle.
- A reset during the tail cycle shows whether the pending write is dropped.

A fixed-seed random phase then mixes all request kinds. Stalled requests are held steady, so chains of stores, fetches and loads arrive at every phase of the tail cycle. Each stall and each returned word is compared with a reference model built from the priority and tail rules.

// File: rtl/tcm_arb_pkg.sv
// Package: shared types for the shared instruction-memory arbiter.
// Assumes: one grant per cycle, encoded as below.
package tcm_arb_pkg;

    // Which port owns the memory in the current cycle.
    typedef enum logic [1:0] {
        GNT_NONE  = 2'd0,
        GNT_FETCH = 2'd1,
        GNT_LOAD  = 2'd2,
        GNT_STORE = 2'd3
    } gnt_e;

endpackage

// File: rtl/tcm_arb_core.sv
// Module: arbitration state machine.
// Picks the owner of the memory each cycle (free store > fetch > load) and
// tracks the tail cycle of a store, in which nobody is granted and the
// latched store is written.
// Assumes: requesters hold address and data steady while stalled.
module tcm_arb_core
    import tcm_arb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_req,
    input  logic              d_req,
    input  logic              d_we,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [DATA_W-1:0] d_wdata,
    output gnt_e              gnt,
    output logic              tail_busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic tail_q;

    // Grant selection for the current cycle.
    always_comb begin
        if (tail_q)                gnt = GNT_NONE;
        else if (d_req && d_we)    gnt = GNT_STORE;
        else if (if_req)           gnt = GNT_FETCH;
        else if (d_req)            gnt = GNT_LOAD;
        else                       gnt = GNT_NONE;
    end

    // Tail-cycle flag: set for exactly the cycle after a store grant.
    always_ff @(posedge clk) begin
        if (!rst_n) tail_q <= 1'b0;
        else        tail_q <= (gnt == GNT_STORE);
    end

    // Latch the store address and data on its grant for the tail write.
    always_ff @(posedge clk) begin
        if (gnt == GNT_STORE) begin
            wr_addr <= d_addr;
            wr_data <= d_wdata;
        end
    end

    // The tail write is dropped if reset arrives during the tail cycle.
    assign wr_en     = tail_q && rst_n;
    assign tail_busy = tail_q;

endmodule

// File: rtl/tcm_sram.sv
// Module: single-port synchronous memory array.
// At most one of read or write is used per cycle. A read registers its
// word at the clock edge; a write updates the array at the clock edge.
// Assumes: the arbiter never asks for a read and a write in the same cycle.
module tcm_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array write on the store tail cycle.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read for a granted fetch or load.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/tcm_port_arbiter.sv
// Module: top of the shared instruction-memory port arbiter.
// Connects the arbitration core to the memory array, steers the read
// address and derives the stall of each port from the grant.
// Assumes: synchronous active-low reset; stalled requests are held steady.
module tcm_port_arbiter
    import tcm_arb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_req,
    input  logic [ADDR_W-1:0] if_addr,
    output logic              if_stall,
    output logic [DATA_W-1:0] if_rdata,
    input  logic              d_req,
    input  logic              d_we,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [DATA_W-1:0] d_wdata,
    output logic              d_stall,
    output logic [DATA_W-1:0] d_rdata
);

    gnt_e              gnt;
    logic              tail_busy;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    tcm_arb_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .if_req    (if_req),
        .d_req     (d_req),
        .d_we      (d_we),
        .d_addr    (d_addr),
        .d_wdata   (d_wdata),
        .gnt       (gnt),
        .tail_busy (tail_busy),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    // Read-port steering from the grant.
    always_comb begin
        rd_en   = (gnt == GNT_FETCH) || (gnt == GNT_LOAD);
        rd_addr = (gnt == GNT_FETCH) ? if_addr : d_addr;
    end

    tcm_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
        .clk     (clk),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // Stall of each port: a request that did not win this cycle.
    always_comb begin
        if_stall = if_req && (gnt != GNT_FETCH);
        d_stall  = d_req && (gnt != GNT_LOAD) && (gnt != GNT_STORE);
    end

    assign if_rdata = rd_data;
    assign d_rdata  = rd_data;

endmodule

// File: rtl/tcm_arb_chk.sv
// Module: property checker for the shared instruction-memory arbiter,
// attached by bind. It observes the ports and the store-tail flag.
module tcm_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic if_req,
    input logic if_stall,
    input logic d_req,
    input logic d_we,
    input logic d_stall,
    input logic tail_busy
);

    // R1: reset leaves no store tail pending.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !tail_busy);

    // R2: a fetch in a free cycle without a competing store is granted.
    p_fetch_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tail_busy && if_req && !(d_req && d_we)) |-> !if_stall);

    // R4: a fetch beats a load in the same free cycle.
    p_fetch_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tail_busy && if_req && d_req && !d_we) |-> (!if_stall && d_stall));

    // R5: the cycle after a granted store serves nobody.
    p_store_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && d_we && !d_stall) |=> ((!if_req || if_stall) && (!d_req || d_stall)));

    // R6: a store in a free cycle wins over a fetch.
    p_store_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tail_busy && d_req && d_we) |-> (!d_stall && (!if_req || if_stall)));

    // R7: the tail lasts exactly one cycle.
    p_tail_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tail_busy |=> !tail_busy);

    // R9: no stall without a request.
    p_quiet_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !if_req |-> !if_stall);
    p_quiet_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !d_req |-> !d_stall);

endmodule

bind tcm_port_arbiter tcm_arb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .if_req    (if_req),
    .if_stall  (if_stall),
    .d_req     (d_req),
    .d_we      (d_we),
    .d_stall   (d_stall),
    .tail_busy (tail_busy)
);

// File: tb/tcm_port_arbiter_tb.sv
module tcm_port_arbiter_tb;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          if_req = 1'b0;
    logic [AW-1:0] if_addr = '0;
    logic          if_stall;
    logic [DW-1:0] if_rdata;
    logic          d_req = 1'b0;
    logic          d_we = 1'b0;
    logic [AW-1:0] d_addr = '0;
    logic [DW-1:0] d_wdata = '0;
    logic          d_stall;
    logic [DW-1:0] d_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_tail = 1'b0;
    logic [AW-1:0] m_pa;
    logic [DW-1:0] m_pd;
    bit            m_rv = 1'b0;
    bit            m_rport;      // 0 = fetch, 1 = load
    logic [DW-1:0] m_rexp;
    string         m_rtag;

    always #5 clk = ~clk;

    tcm_port_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .if_req(if_req), .if_addr(if_addr), .if_stall(if_stall), .if_rdata(if_rdata),
        .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
        .d_stall(d_stall), .d_rdata(d_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected owner from the rules: 0 none, 1 fetch, 2 load, 3 store
    function automatic int exp_gnt(bit tail, bit fi, bit dq, bit dw);
        if (tail)          return 0;
        if (dq && dw)      return 3;
        if (fi)            return 1;
        if (dq)            return 2;
        return 0;
    endfunction

    function automatic logic [DW-1:0] pat(int a);
        return 32'hA5A5_0000 ^ (a * 32'h0101_0033);
    endfunction

    // One cycle: drive at negedge, check stalls, update model at posedge.
    // ei/ed: fixed expected stall, or -1 to take it from the model.
    task automatic step(input bit fi, input logic [AW-1:0] fa,
                        input bit dq, input bit dw, input logic [AW-1:0] da,
                        input logic [DW-1:0] dd, input string tag,
                        input int ei, input int ed);
        int g;
        bit xi, xd;
        if_req = fi; if_addr = fa;
        d_req = dq; d_we = dw; d_addr = da; d_wdata = dd;
        #1;
        if (m_rv) begin
            if (m_rport) chk(d_rdata === m_rexp, m_rtag, d_rdata, m_rexp);
            else         chk(if_rdata === m_rexp, m_rtag, if_rdata, m_rexp);
        end
        g  = exp_gnt(m_tail, fi, dq, dw);
        xi = fi && (g != 1);
        xd = dq && (g != 2) && (g != 3);
        if (ei >= 0) xi = (ei != 0);
        if (ed >= 0) xd = (ed != 0);
        chk(if_stall === xi, {tag, " fetch stall"}, {31'd0, if_stall}, {31'd0, xi});
        chk(d_stall === xd, {tag, " data stall"}, {31'd0, d_stall}, {31'd0, xd});
        @(posedge clk);
        g = exp_gnt(m_tail, fi, dq, dw);
        m_rv = 1'b0;
        if (m_tail) begin
            m_mem[m_pa] = m_pd;
            m_tail = 1'b0;
        end else if (g == 3) begin
            m_pa = da; m_pd = dd; m_tail = 1'b1;
        end else if (g == 1) begin
            m_rv = 1'b1; m_rport = 1'b0; m_rexp = m_mem[fa]; m_rtag = {tag, " rdata R2/R8"};
        end else if (g == 2) begin
            m_rv = 1'b1; m_rport = 1'b1; m_rexp = m_mem[da]; m_rtag = {tag, " rdata R3/R8"};
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b0, 1'b0, '0, '0, tag, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit hold_i, hold_d;
        bit ci, cq, cw;
        logic [AW-1:0] cia, cda;
        logic [DW-1:0] cdd;
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(if_stall === 1'b0 && d_stall === 1'b0, "R1 stalls in reset", {30'd0, if_stall, d_stall}, 0);
        rst_n = 1'b1;

        // R1: fetch right after reset is not stalled
        step(1'b1, 6'd0, 1'b0, 1'b0, '0, '0, "R1", 0, 0);
        idle("R1 idle");

        // Fill memory: isolated stores never stall (R8 later reads)
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b0, '0, 1'b1, 1'b1, a[AW-1:0], pat(a), "R5 fill", 0, 0);
            idle("R5 fill tail");
        end

        // R2: single and back-to-back fetches
        step(1'b1, 6'd5, 1'b0, 1'b0, '0, '0, "R2", 0, 0);
        step(1'b1, 6'd6, 1'b0, 1'b0, '0, '0, "R2 seq", 0, 0);
        step(1'b1, 6'd7, 1'b0, 1'b0, '0, '0, "R2 seq", 0, 0);
        idle("R2 idle");

        // R3: lone load
        step(1'b0, '0, 1'b1, 1'b0, 6'd9, '0, "R3", 0, 0);
        idle("R3 idle");

        // R4: fetch and load together, load loses exactly one cycle
        step(1'b1, 6'd1, 1'b1, 1'b0, 6'd2, '0, "R4", 0, 1);
        step(1'b0, '0, 1'b1, 1'b0, 6'd2, '0, "R4 retry", 0, 0);
        idle("R4 idle");

        // R6: store and fetch together, fetch loses two cycles
        step(1'b1, 6'd3, 1'b1, 1'b1, 6'd4, 32'hCAFE_0004, "R6", 1, 0);
        step(1'b1, 6'd3, 1'b0, 1'b0, '0, '0, "R6 tail", 1, 0);
        step(1'b1, 6'd3, 1'b0, 1'b0, '0, '0, "R6 grant", 0, 0);
        idle("R6 idle");

        // R5/R7/R8: store then load of same address
        step(1'b0, '0, 1'b1, 1'b1, 6'd10, 32'h1234_5678, "R7 store", 0, 0);
        step(1'b0, '0, 1'b1, 1'b0, 6'd10, '0, "R7 load after store", 0, 1);
        step(1'b0, '0, 1'b1, 1'b0, 6'd10, '0, "R7 load grant", 0, 0);
        idle("R8 readback");

        // R7: store, store, then fetch in the second store's grant cycle
        step(1'b0, '0, 1'b1, 1'b1, 6'd11, 32'h0000_0B0B, "R7 st1", 0, 0);
        step(1'b0, '0, 1'b1, 1'b1, 6'd12, 32'h0000_0C0C, "R7 st2 wait", 0, 1);
        step(1'b1, 6'd12, 1'b1, 1'b1, 6'd12, 32'h0000_0C0C, "R7 st2 grant", 1, 0);
        step(1'b1, 6'd12, 1'b0, 1'b0, '0, '0, "R7 fetch tail", 1, 0);
        step(1'b1, 6'd12, 1'b0, 1'b0, '0, '0, "R7 fetch grant R8", 0, 0);
        idle("R7 idle");

        // R5: store followed by fetch loses one cycle
        step(1'b0, '0, 1'b1, 1'b1, 6'd13, 32'h0000_0D0D, "R5 store", 0, 0);
        step(1'b1, 6'd13, 1'b0, 1'b0, '0, '0, "R5 fetch in tail", 1, 0);
        step(1'b1, 6'd13, 1'b0, 1'b0, '0, '0, "R5 fetch grant", 0, 0);
        idle("R5 idle");

        // R10: reset in the tail cycle cancels the write
        step(1'b0, '0, 1'b1, 1'b1, 6'd14, 32'hDEAD_BEEF, "R10 store", 0, 0);
        if_req = 1'b0; d_req = 1'b0; d_we = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        m_tail = 1'b0; m_rv = 1'b0;      // write dropped: model keeps old word
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 6'd0, 1'b0, 1'b0, '0, '0, "R1 after reset", 0, 0);
        step(1'b0, '0, 1'b1, 1'b0, 6'd14, '0, "R10 load", 0, 0);
        idle("R10 readback");
        chk(d_rdata === pat(14), "R10 old word kept", d_rdata, pat(14));

        // Random phase with held stalled requests
        hold_i = 1'b0; hold_d = 1'b0;
        ci = 0; cq = 0; cw = 0; cia = '0; cda = '0; cdd = '0;
        for (int n = 0; n < 3000; n++) begin
            int gg;
            if (!hold_i) begin
                ci  = ($urandom % 2) == 0;
                cia = AW'($urandom);
            end
            if (!hold_d) begin
                cq  = ($urandom % 3) != 0;
                cw  = ($urandom % 2) == 0;
                cda = AW'($urandom % 16);
                cdd = $urandom;
            end
            gg = exp_gnt(m_tail, ci, cq, cw);
            hold_i = ci && (gg != 1);
            hold_d = cq && (gg != 2) && (gg != 3);
            step(ci, cia, cq, cw, cda, cdd, "R9 random", -1, -1);
        end
        idle("final");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule